// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block decides which clock domains of a small microcontroller run. Software writes a control field that holds a sleep-enable flag and a three-bit mode. When the core then raises a sleep request, the controller drops the clock enables for the CPU, I/O, non-volatile-memory and ADC domains, and also the oscillator enable, according to the chosen mode. It then watches the wake sources that the mode allows. When a qualified wake event arrives, it restores the clocks. After the deepest mode it first waits a programmable oscillator start-up time, counted in ticks of a free-running slow clock.

A second register holds one gate bit per peripheral. A set bit stops that peripheral's clock, so its state stays frozen. The same bit also blocks the peripheral's register port: reads return zero and writes are suppressed. Clearing the bit lets the peripheral resume from the frozen state. Every clock enable is registered on the falling edge of the main clock, so the downstream clock gates see no glitch.

Top module: `sleep_ctrl`

## Requirements
- R1: During and after synchronous reset, all five clock enables and every peripheral clock enable are high, the gate register is zero, the control field is zero and `adc_start` is low.
- R2: Mode 000 (idle), and the reserved values 011, 101, 110 and 111, stop only the CPU clock while asleep.
- R3: Mode 001 stops the CPU, I/O and NVM clocks and keeps the ADC clock and the oscillator running. Entering this mode with `adc_en` high gives a `adc_start` pulse exactly one cycle wide, and with `adc_en` low no pulse.
- R4: Mode 010 (deep power-down) drives all four domain enables and `osc_en` low.
- R5: Mode 100 (standby) drives all four domain enables low, keeps `osc_en` high, and restores every clock in the cycle after the wake event is sampled.
- R6: In modes 010 and 100, only `wk_wdt`, `wk_int0_lvl` or `wk_pcint` wake the block. `wk_int0_edge` and `wk_irq` leave it asleep.
- R7: In idle, in reserved modes and in mode 001, any of the five wake inputs wakes the block in the next cycle.
- R8: After a wake from mode 010, `osc_en` rises in the next cycle. The domain enables stay low until STARTUP_TICKS `slow_tick` pulses have been counted, and they rise in the cycle after the last of those pulses.
- R9: A sleep request while the enable flag (`ctl_wdata[3]`, with the mode in `ctl_wdata[2:0]`) is clear has no effect and all clocks stay on.
- R10: Clock enable outputs change only on falling clock edges. Values seen just after a rising edge equal those seen before it.
- R11: `periph_ce[i]` is high exactly when the I/O clock is enabled and gate bit i is clear. Clearing the bit restores the clock.
- R12: For a peripheral selected by `bus_sel` whose gate bit is set, `bus_rdata` is zero and `per_wr` stays all-zero. For a peripheral whose bit is clear, a read returns its slice of `per_rdata` (slice i at bits i*DW upward) and a write raises `per_wr[i]`. With `bus_rd` low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control field |
| ctl_wdata | input | 4 | Bit 3 sleep enable, bits 2:0 mode |
| sleep_req | input | 1 | Sleep request from the core |
| adc_en | input | 1 | ADC is enabled |
| wk_wdt | input | 1 | Watchdog reset event |
| wk_int0_lvl | input | 1 | Level-type external interrupt 0 |
| wk_int0_edge | input | 1 | Edge-type external interrupt 0 |
| wk_pcint | input | 1 | Pin-change interrupt |
| wk_irq | input | 1 | Any other enabled interrupt |
| slow_tick | input | 1 | One-cycle tick of the free-running slow clock |
| prr_wr | input | 1 | Write strobe for the gate register |
| prr_wdata | input | NPER | New gate bits |
| bus_sel | input | $clog2(NPER) | Peripheral selected on the register bus |
| bus_rd | input | 1 | Register read |
| bus_wr | input | 1 | Register write |
| per_rdata | input | NPER*DW | Read data from each peripheral |
| bus_rdata | output | DW | Gated read data |
| per_wr | output | NPER | Gated write strobe per peripheral |
| cpu_ce | output | 1 | CPU clock enable |
| io_ce | output | 1 | I/O clock enable |
| nvm_ce | output | 1 | NVM clock enable |
| adc_ce | output | 1 | ADC clock enable |
| osc_en | output | 1 | Oscillator enable |
| periph_ce | output | NPER | Per-peripheral clock enable |
| adc_start | output | 1 | One-cycle conversion start |

## Verification
The hardest state to reach is the start-up wait after deep power-down. Only a qualified wake from mode 010 gets there, and the block then stays in it for STARTUP_TICKS slow ticks. To reach it, the stimulus first sends the ignored edge interrupt and general interrupt while the block is in power-down. It then wakes the block with a pin change and lets the bench's slow tick run every fourth cycle, so a behavioural model can follow each count toward the release. Standby is driven the same way to show that clocks return at once, because no counter is involved.

// File: rtl/sleep_pkg.sv
// Shared types for the sleep controller.
package sleep_pkg;
    // Operating plan decoded from the three-bit mode field.
    typedef enum logic [1:0] {
        PLAN_IDLE = 2'd0,
        PLAN_ADCQ = 2'd1,
        PLAN_DEEP = 2'd2,
        PLAN_STBY = 2'd3
    } plan_e;

    // Controller state.
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WARM  = 2'd2
    } state_e;

    // One enable per clock domain plus the oscillator.
    typedef struct packed {
        logic cpu;
        logic io;
        logic nvm;
        logic adc;
        logic osc;
    } ce_t;
endpackage

// File: rtl/slp_mode_decode.sv
// Maps the raw mode field to a plan.
// Assumes: any code other than 001, 010 and 100 is reserved and is treated as idle.
module slp_mode_decode
    import sleep_pkg::*;
(
    input  logic [2:0] mode_i,
    output plan_e      plan_o
);
    // Decode the mode code into a plan.
    always_comb begin
        case (mode_i)
            3'b001:  plan_o = PLAN_ADCQ;
            3'b010:  plan_o = PLAN_DEEP;
            3'b100:  plan_o = PLAN_STBY;
            default: plan_o = PLAN_IDLE;
        endcase
    end
endmodule

// File: rtl/slp_fsm.sv
// Sleep sequencer. It enters sleep on a qualified request, filters wake events
// by plan, and counts oscillator start-up ticks after deep power-down.
// Assumes: slow_tick is a one-cycle pulse synchronous to clk, and STARTUP_TICKS >= 2.
module slp_fsm
    import sleep_pkg::*;
#(
    parameter int STARTUP_TICKS = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep_req,
    input  logic   sleep_en,
    input  plan_e  plan_req,
    input  logic   adc_en,
    input  logic   wk_wdt,
    input  logic   wk_lvl,
    input  logic   wk_edge,
    input  logic   wk_pc,
    input  logic   wk_irq,
    input  logic   slow_tick,
    output state_e state_o,
    output plan_e  plan_o,
    output logic   adc_start_o
);
    localparam int CW = $clog2(STARTUP_TICKS);
    localparam logic [CW-1:0] LAST = CW'(STARTUP_TICKS - 1);

    state_e        st_q;
    plan_e         plan_q;
    logic [CW-1:0] cnt_q;
    logic          deep_plan;
    logic          wake_hit;

    // Deep plans accept only the asynchronous-capable wake sources.
    always_comb begin
        deep_plan = (plan_q == PLAN_DEEP) || (plan_q == PLAN_STBY);
        wake_hit  = wk_wdt | wk_lvl | wk_pc | (~deep_plan & (wk_edge | wk_irq));
    end

    // State, latched plan, start-up counter and conversion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_RUN;
            plan_q      <= PLAN_IDLE;
            cnt_q       <= '0;
            adc_start_o <= 1'b0;
        end else begin
            adc_start_o <= 1'b0;
            case (st_q)
                ST_RUN: begin
                    if (sleep_req && sleep_en) begin
                        st_q        <= ST_SLEEP;
                        plan_q      <= plan_req;
                        adc_start_o <= (plan_req == PLAN_ADCQ) && adc_en;
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit) begin
                        cnt_q <= '0;
                        st_q  <= (plan_q == PLAN_DEEP) ? ST_WARM : ST_RUN;
                    end
                end
                ST_WARM: begin
                    if (slow_tick) begin
                        if (cnt_q == LAST) begin
                            st_q  <= ST_RUN;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    assign state_o = st_q;
    assign plan_o  = plan_q;

    // R9
    se_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !sleep_en) |=> (st_q == ST_RUN));
    // R6
    deep_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && deep_plan && !wk_wdt && !wk_lvl && !wk_pc) |=> (st_q == ST_SLEEP));
    // R8
    warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WARM && !slow_tick) |=> (st_q == ST_WARM));
    // R3
    adc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);
endmodule

// File: rtl/slp_ce_out.sv
// Builds the wanted clock enables from state and plan, and registers them on
// the falling clock edge so the downstream clock gates are glitch-free.
// Assumes: the gate register is stable around the falling edge (it changes on rising edges).
module slp_ce_out
    import sleep_pkg::*;
#(
    parameter int NPER = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  state_e          state_i,
    input  plan_e           plan_i,
    input  logic [NPER-1:0] gate_i,
    output ce_t             ce_o,
    output logic [NPER-1:0] periph_ce_o
);
    ce_t want;

    // Domain plan per state and sleep plan.
    always_comb begin
        want = '{cpu: 1'b1, io: 1'b1, nvm: 1'b1, adc: 1'b1, osc: 1'b1};
        if (state_i == ST_WARM) begin
            want = '{cpu: 1'b0, io: 1'b0, nvm: 1'b0, adc: 1'b0, osc: 1'b1};
        end else if (state_i == ST_SLEEP) begin
            case (plan_i)
                PLAN_IDLE: want.cpu = 1'b0;
                PLAN_ADCQ: want = '{cpu: 1'b0, io: 1'b0, nvm: 1'b0, adc: 1'b1, osc: 1'b1};
                PLAN_DEEP: want = '0;
                default:   want = '{cpu: 1'b0, io: 1'b0, nvm: 1'b0, adc: 1'b0, osc: 1'b1};
            endcase
        end
    end

    // Falling-edge output register for all clock enables.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            ce_o        <= '1;
            periph_ce_o <= '1;
        end else begin
            ce_o        <= want;
            periph_ce_o <= {NPER{want.io}} & ~gate_i;
        end
    end

    // R4
    osc_off_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_o.osc |-> (ce_o == '0));
    // R11
    periph_follow_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_o.io |-> (periph_ce_o == '0));
endmodule

// File: rtl/slp_prr_gate.sv
// Per-peripheral gate register with register-port masking. A set bit returns
// zero on reads and suppresses writes to that peripheral.
// Assumes: bus_sel addresses an existing peripheral (below NPER).
module slp_prr_gate #(
    parameter int NPER = 4,
    parameter int DW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prr_wr,
    input  logic [NPER-1:0]         prr_wdata,
    input  logic [$clog2(NPER)-1:0] bus_sel,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [NPER*DW-1:0]      per_rdata,
    output logic [NPER-1:0]         gate_o,
    output logic [DW-1:0]           bus_rdata,
    output logic [NPER-1:0]         per_wr
);
    logic [DW-1:0] masked [NPER];

    // Gate register update.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_o <= '0;
        else if (prr_wr) gate_o <= prr_wdata;
    end

    // One masked read path and write strobe per peripheral.
    for (genvar i = 0; i < NPER; i++) begin : g_port
        logic hit;
        assign hit       = (bus_sel == i) && !gate_o[i];
        assign masked[i] = (hit && bus_rd) ? per_rdata[i*DW +: DW] : '0;
        assign per_wr[i] = hit && bus_wr;
    end

    // Merge the masked read slices.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NPER; k++) bus_rdata = bus_rdata | masked[k];
    end

    // R12
    gated_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && gate_o[bus_sel]) |-> (bus_rdata == '0));
    // R12
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && gate_o[bus_sel]) |-> (per_wr == '0));
    // R12
    write_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_wr));
endmodule

// File: rtl/sleep_ctrl.sv
// Top of the sleep controller. It holds the control field, decodes the mode,
// sequences sleep and wake, drives the clock enables and gates peripheral access.
// Assumes: the wake inputs are already synchronised to clk.
module sleep_ctrl
    import sleep_pkg::*;
#(
    parameter int NPER          = 4,
    parameter int DW            = 8,
    parameter int STARTUP_TICKS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_wr,
    input  logic [3:0]              ctl_wdata,
    input  logic                    sleep_req,
    input  logic                    adc_en,
    input  logic                    wk_wdt,
    input  logic                    wk_int0_lvl,
    input  logic                    wk_int0_edge,
    input  logic                    wk_pcint,
    input  logic                    wk_irq,
    input  logic                    slow_tick,
    input  logic                    prr_wr,
    input  logic [NPER-1:0]         prr_wdata,
    input  logic [$clog2(NPER)-1:0] bus_sel,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [NPER*DW-1:0]      per_rdata,
    output logic [DW-1:0]           bus_rdata,
    output logic [NPER-1:0]         per_wr,
    output logic                    cpu_ce,
    output logic                    io_ce,
    output logic                    nvm_ce,
    output logic                    adc_ce,
    output logic                    osc_en,
    output logic [NPER-1:0]         periph_ce,
    output logic                    adc_start
);
    logic [3:0]      ctl_q;
    plan_e           plan_req;
    plan_e           plan_cur;
    state_e          state;
    ce_t             ce;
    logic [NPER-1:0] gate;

    // Control field: sleep enable and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    slp_mode_decode u_dec (
        .mode_i (ctl_q[2:0]),
        .plan_o (plan_req)
    );

    slp_fsm #(.STARTUP_TICKS(STARTUP_TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .sleep_en    (ctl_q[3]),
        .plan_req    (plan_req),
        .adc_en      (adc_en),
        .wk_wdt      (wk_wdt),
        .wk_lvl      (wk_int0_lvl),
        .wk_edge     (wk_int0_edge),
        .wk_pc       (wk_pcint),
        .wk_irq      (wk_irq),
        .slow_tick   (slow_tick),
        .state_o     (state),
        .plan_o      (plan_cur),
        .adc_start_o (adc_start)
    );

    slp_ce_out #(.NPER(NPER)) u_ce (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .plan_i      (plan_cur),
        .gate_i      (gate),
        .ce_o        (ce),
        .periph_ce_o (periph_ce)
    );

    slp_prr_gate #(.NPER(NPER), .DW(DW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .prr_wr    (prr_wr),
        .prr_wdata (prr_wdata),
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .per_rdata (per_rdata),
        .gate_o    (gate),
        .bus_rdata (bus_rdata),
        .per_wr    (per_wr)
    );

    assign cpu_ce = ce.cpu;
    assign io_ce  = ce.io;
    assign nvm_ce = ce.nvm;
    assign adc_ce = ce.adc;
    assign osc_en = ce.osc;

    // R5
    stby_osc_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && plan_cur == PLAN_STBY && !ce.cpu) |-> osc_en);
    // R2
    cpu_first_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ce |-> !cpu_ce);
endmodule

// File: tb/tb_sleep_ctrl.sv
// Bench for sleep_ctrl: a behavioural model stepped on each rising edge, with
// the outputs compared just before and just after each falling edge.
module tb_sleep_ctrl;
    localparam int NPER = 4;
    localparam int DW   = 8;
    localparam int SU   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, sleep_req = 0, adc_en = 0;
    logic [3:0] ctl_wdata = '0;
    logic wk_wdt = 0, wk_int0_lvl = 0, wk_int0_edge = 0, wk_pcint = 0, wk_irq = 0;
    logic slow_tick = 0, prr_wr = 0, bus_rd = 0, bus_wr = 0;
    logic [NPER-1:0] prr_wdata = '0;
    logic [1:0] bus_sel = '0;
    logic [NPER*DW-1:0] per_rdata = 32'hA35C_7E11;
    logic [DW-1:0] bus_rdata;
    logic [NPER-1:0] per_wr, periph_ce;
    logic cpu_ce, io_ce, nvm_ce, adc_ce, osc_en, adc_start;

    sleep_ctrl #(.NPER(NPER), .DW(DW), .STARTUP_TICKS(SU)) dut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit chk_on = 0, have_prev = 0, done = 0;
    // Model state: 0 running, 1 asleep, 2 oscillator warm-up.
    int m_st = 0, m_kind = 0, m_cnt = 0;
    logic [3:0] m_ctl = '0;
    logic [NPER-1:0] m_prr = '0;
    logic m_adc = 0;
    logic [4:0] prev_ce;

    function automatic int kind_of(input logic [2:0] m);
        if (m == 3'b001) return 1;
        if (m == 3'b010) return 2;
        if (m == 3'b100) return 3;
        return 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_kind = 0; m_cnt = 0; m_ctl = '0; m_prr = '0; m_adc = 0;
        end else begin
            m_adc = 0;
            if (m_st == 0) begin
                if (sleep_req && m_ctl[3]) begin
                    m_st = 1;
                    m_kind = kind_of(m_ctl[2:0]);
                    m_adc = (m_kind == 1) && adc_en;
                end
            end else if (m_st == 1) begin
                if (wk_wdt || wk_int0_lvl || wk_pcint ||
                    (m_kind < 2 && (wk_int0_edge || wk_irq))) begin
                    m_st = (m_kind == 2) ? 2 : 0;
                    m_cnt = 0;
                end
            end else if (slow_tick) begin
                m_cnt++;
                if (m_cnt == SU) begin m_st = 0; m_cnt = 0; end
            end
            if (ctl_wr) m_ctl = ctl_wdata;
            if (prr_wr) m_prr = prr_wdata;
        end
    end

    // Compare outputs before (R10) and after each falling edge.
    always begin
        logic [4:0] e;
        logic [NPER-1:0] pe, ew;
        logic [DW-1:0] er;
        string rq;
        @(posedge clk);
        #5;
        if (chk_on && have_prev)
            check("R10", {cpu_ce, io_ce, nvm_ce, adc_ce, osc_en}, prev_ce);
        #10;
        if (chk_on) begin
            e[4] = (m_st == 0);
            e[3] = (m_st == 0) || (m_st == 1 && m_kind == 0);
            e[2] = e[3];
            e[1] = (m_st == 0) || (m_st == 1 && m_kind <= 1);
            e[0] = !(m_st == 1 && m_kind == 2);
            if (!rst_n || m_st == 0) rq = "R1";
            else if (m_st == 2) rq = "R8";
            else if (m_kind == 0) rq = "R2";
            else if (m_kind == 1) rq = "R3";
            else if (m_kind == 2) rq = "R4";
            else rq = "R5";
            check(rq, {cpu_ce, io_ce, nvm_ce, adc_ce, osc_en}, e);
            check("R3", adc_start, m_adc);
            pe = {NPER{e[3]}} & ~m_prr;
            check("R11", periph_ce, pe);
            er = (bus_rd && !m_prr[bus_sel]) ? per_rdata[bus_sel*DW +: DW] : '0;
            ew = (bus_wr && !m_prr[bus_sel]) ? (NPER'(1) << bus_sel) : '0;
            check("R12", {bus_rdata, per_wr}, {er, ew});
            prev_ce = e;
            have_prev = 1;
        end
    end

    // Free-running slow clock tick, one every fourth cycle.
    initial begin
        forever begin
            @(posedge clk); #2;
            slow_tick = (cyc % 4 == 3);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        ctl_wr = 1; ctl_wdata = v; step(1); ctl_wr = 0;
    endtask

    task automatic go_sleep();
        sleep_req = 1; step(1); sleep_req = 0;
    endtask

    task automatic pulse(ref logic s);
        s = 1; step(1); s = 0;
    endtask

    // Watchdog.
    initial begin
        step(20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        step(1); chk_on = 1;
        step(3); rst_n = 1;      // R1 reset values checked above
        step(2);
        // R9: request with the enable flag clear, mode power-down
        wr_ctl(4'b0010); go_sleep(); step(4);
        // R2 idle, then R7 wake on a general interrupt
        wr_ctl(4'b1000); go_sleep(); step(3); pulse(wk_irq); step(2);
        // R2 reserved code 011, R7 wake on an edge interrupt
        wr_ctl(4'b1011); go_sleep(); step(3); pulse(wk_int0_edge); step(2);
        // R3 with the ADC enabled: pulse, R7 wake on pin change
        adc_en = 1; wr_ctl(4'b1001); go_sleep(); step(3); pulse(wk_pcint); step(2);
        // R3 with the ADC disabled: no pulse, R7 wake on watchdog
        adc_en = 0; go_sleep(); step(3); pulse(wk_wdt); step(2);
        // R5 standby, R6 ignored sources, then a level interrupt wakes next cycle
        wr_ctl(4'b1100); go_sleep(); step(2);
        pulse(wk_irq); pulse(wk_int0_edge); step(2);
        pulse(wk_int0_lvl); step(3);
        // R4 power-down, R6 ignored sources, R8 start-up count after pin change
        wr_ctl(4'b1010); go_sleep(); step(2);
        pulse(wk_int0_edge); pulse(wk_irq); step(3);
        pulse(wk_pcint); step(SU * 4 + 6);
        // R11 and R12: gate peripherals 0 and 2, then access all four
        prr_wr = 1; prr_wdata = 4'b0101; step(1); prr_wr = 0;
        for (int s = 0; s < NPER; s++) begin
            bus_sel = 2'(s); bus_rd = 1; step(1); bus_rd = 0; bus_wr = 1; step(1); bus_wr = 0;
        end
        // R11 gate held through idle sleep, then released
        wr_ctl(4'b1000); go_sleep(); step(2); pulse(wk_irq);
        prr_wr = 1; prr_wdata = 4'b0000; step(1); prr_wr = 0;
        bus_sel = 2'd2; bus_rd = 1; step(1); bus_rd = 0;
        step(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule